// File: doc/BRIEF.md
# Multiplexed Address/Data Asynchronous Read Engine

This block performs one asynchronous read at a time from an external device whose low address bits and read data travel on one shared 16-bit bus. A requester presents a byte address and a chip-select index while the engine is idle, and the engine takes it on a valid/ready handshake. Each chip select has its own timing words. Every strobe edge is an offset, in clock cycles, from the first cycle of the access. The engine samples these words when it takes the request and holds them until the access ends.

During the address phase the engine drives byte-address bits 16..1 onto the shared bus and the bits above 16 onto a separate high-address bus. When output enable asserts, the address phase ends: the direction line turns to input and the engine stops driving the shared bus. The device then returns data. The engine captures it at the programmed access time. At the programmed cycle time it presents the data with a one-cycle done pulse, and it goes idle on the next cycle.

Cycle numbering: the cycle after the accepting clock edge is access cycle k = 0, and k counts up by one each clock. A strobe programmed with on time `on` and off time `off` is active during cycles on <= k < off.

Top module: `mux_rd_engine`

## Requirements
- R1: After reset, and on every cycle the engine is idle, `req_ready` is 1. All `cs_n` bits, `adv_n` and `oe_n` are 1, `be_n` is 2'b11, `dir_out` is 1 (1 = OUT, 0 = IN), `ad_oe` is 0 and `rd_done` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. While an access runs, `req_ready` is 0, and `req_valid`, `req_cs` and `req_addr` have no effect on any output.
- R3: From access cycle 0 until output enable asserts, `ad_out` equals request address bits 16..1 and `a_hi` equals request address bits ADDR_W-1..17.
- R4: The selected chip select `cs_n[req_cs]` is 0 exactly during cycles on <= k < off. Here `on` is bits 3:0 and `off` is bits 12:8 of that chip select's word in `cfg_cs_words` (word i occupies bits 13*i+12 .. 13*i).
- R5: `adv_n` is 0 exactly during on <= k < off. Here `on` is bits 3:0 and `off` is bits 12:8 of the selected 13-bit word in `cfg_adv_words`.
- R6: `oe_n` is 0 exactly during on <= k < off. Here `on` is bits 4:0 and `off` is bits 12:8 of the selected 29-bit word in `cfg_oe_words` (word i at bits 29*i+28 .. 29*i).
- R7: For k below the output-enable on time, `dir_out` is 1 and `ad_oe` is 1. From the output-enable on time to the end of the access, `dir_out` is 0 and `ad_oe` is 0.
- R8: `rd_data` takes the value of `ad_in` at the clock edge that ends cycle k = acc, where acc is bits 20:16 of the selected `cfg_oe_words` word. Later changes of `ad_in` do not alter it.
- R9: `rd_done` is 1 for exactly the one cycle k = cyc, where cyc is bits 28:24 of the selected `cfg_oe_words` word. In that cycle `rd_data` holds the captured value, and the engine is idle on the following cycle.
- R10: During an access only the selected chip-select bit can go low, and the timing words used are those of that chip select.
- R11: `be_n` is 2'b00 for every cycle of an access, from k = 0 through k = cyc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_cs | input | SEL_W | Chip-select index of the request |
| req_addr | input | ADDR_W | Byte address of the request |
| cfg_cs_words | input | NUM_CS*13 | Per-CS chip-select on/off times |
| cfg_adv_words | input | NUM_CS*13 | Per-CS address-valid on/off times |
| cfg_oe_words | input | NUM_CS*29 | Per-CS output-enable on/off, access time, cycle time |
| cs_n | output | NUM_CS | Active-low chip selects |
| adv_n | output | 1 | Active-low address valid |
| oe_n | output | 1 | Active-low output enable |
| be_n | output | 2 | Active-low byte enables |
| dir_out | output | 1 | Bus direction, 1 = OUT, 0 = IN |
| ad_oe | output | 1 | Tristate enable for the shared bus |
| ad_out | output | 16 | Address bits driven onto the shared bus |
| ad_in | input | 16 | Value read from the shared bus |
| a_hi | output | ADDR_W-17 | High address bus |
| rd_data | output | 16 | Captured read data |
| rd_done | output | 1 | One-cycle read-complete pulse |

## Verification
Several events can land on the same clock edge. The data capture at the access time can coincide with output enable deasserting: when acc = off - 1, the edge that samples `ad_in` is the same edge that raises `oe_n`. The output-enable on time can also equal the address-valid off time, so the bus turnaround and the end of address valid share one edge. Directed accesses set up both coincidences. The random mix also produces them.

The bench drives a new random value onto `ad_in` in every cycle, so a capture that is one cycle early or late returns the wrong word. Expected strobe levels are computed for each cycle from the window rule and compared at every cycle of every access.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int AD_W     = 16;
    localparam int CNT_W    = 5;
    localparam int SHORT_W  = 13;
    localparam int LONG_W   = 29;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cs_on;
        cnt_t cs_off;
        cnt_t adv_on;
        cnt_t adv_off;
        cnt_t oe_on;
        cnt_t oe_off;
        cnt_t acc;
        cnt_t cyc;
    } tim_t;

    function automatic tim_t unpack_tim(input logic [SHORT_W-1:0] cw,
                                        input logic [SHORT_W-1:0] aw,
                                        input logic [LONG_W-1:0]  ow);
        tim_t t;
        t.cs_on   = {1'b0, cw[3:0]};
        t.cs_off  = cw[12:8];
        t.adv_on  = {1'b0, aw[3:0]};
        t.adv_off = aw[12:8];
        t.oe_on   = ow[4:0];
        t.oe_off  = ow[12:8];
        t.acc     = ow[20:16];
        t.cyc     = ow[28:24];
        return t;
    endfunction

    function automatic logic in_window(input cnt_t k, input cnt_t on, input cnt_t off);
        return (k >= on) && (k < off);
    endfunction

endpackage

// File: rtl/mrd_cfg_sel.sv
module mrd_cfg_sel
    import mrd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic [NUM_CS*SHORT_W-1:0] cs_words,
    input  logic [NUM_CS*SHORT_W-1:0] adv_words,
    input  logic [NUM_CS*LONG_W-1:0]  oe_words,
    output tim_t                      tim
);

    tim_t per_cs [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
        assign per_cs[i] = unpack_tim(cs_words[i*SHORT_W +: SHORT_W],
                                      adv_words[i*SHORT_W +: SHORT_W],
                                      oe_words[i*LONG_W +: LONG_W]);
    end

    always_comb begin
        tim = per_cs[0];
        for (int i = 1; i < NUM_CS; i++) begin
            if (sel == SEL_W'(i)) tim = per_cs[i];
        end
    end

endmodule

// File: rtl/mrd_sequencer.sv
module mrd_sequencer
    import mrd_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  tim_t              tim_in,
    input  logic [AD_W-1:0]   ad_in,
    output logic              req_ready,
    output logic              busy_nxt,
    output cnt_t              cnt_nxt,
    output tim_t              tim_nxt,
    output logic [SEL_W-1:0]  sel_nxt,
    output logic [ADDR_W-1:0] addr_q,
    output logic [AD_W-1:0]   rd_data,
    output logic              rd_done
);

    logic             busy_q;
    cnt_t             cnt_q;
    tim_t             tim_q;
    logic [SEL_W-1:0] sel_q;
    logic             accept;
    logic             last;

    assign req_ready = !busy_q;
    assign accept    = req_valid && !busy_q;
    assign last      = busy_q && (cnt_q == tim_q.cyc);

    always_comb begin
        busy_nxt = busy_q;
        cnt_nxt  = cnt_q;
        tim_nxt  = tim_q;
        sel_nxt  = sel_q;
        if (accept) begin
            busy_nxt = 1'b1;
            cnt_nxt  = '0;
            tim_nxt  = tim_in;
            sel_nxt  = req_cs;
        end else if (last) begin
            busy_nxt = 1'b0;
            cnt_nxt  = '0;
        end else if (busy_q) begin
            cnt_nxt  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            tim_q   <= '0;
            sel_q   <= '0;
            addr_q  <= '0;
            rd_data <= '0;
            rd_done <= 1'b0;
        end else begin
            busy_q  <= busy_nxt;
            cnt_q   <= cnt_nxt;
            tim_q   <= tim_nxt;
            sel_q   <= sel_nxt;
            rd_done <= busy_nxt && (cnt_nxt == tim_nxt.cyc);
            if (accept) addr_q <= req_addr;
            if (busy_q && (cnt_q == tim_q.acc)) rd_data <= ad_in;
        end
    end

    // R2: a taken request opens an access at cycle zero
    p_accept_start_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy_q && cnt_q == '0));

    // R9: done lasts one cycle and is followed by idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> (!rd_done && req_ready));

    // R9: done only appears while an access runs
    p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> busy_q);

    // R2: the counter advances by one each busy cycle before the end
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/mrd_strobe.sv
module mrd_strobe
    import mrd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  cnt_t cnt,
    input  cnt_t on,
    input  cnt_t off,
    output logic act_n
);

    always_ff @(posedge clk) begin
        if (rst) act_n <= 1'b1;
        else     act_n <= !(en && in_window(cnt, on, off));
    end

endmodule

// File: rtl/mux_rd_engine.sv
module mux_rd_engine
    import mrd_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 28,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [SEL_W-1:0]          req_cs,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [NUM_CS*SHORT_W-1:0] cfg_cs_words,
    input  logic [NUM_CS*SHORT_W-1:0] cfg_adv_words,
    input  logic [NUM_CS*LONG_W-1:0]  cfg_oe_words,
    output logic [NUM_CS-1:0]         cs_n,
    output logic                      adv_n,
    output logic                      oe_n,
    output logic [1:0]                be_n,
    output logic                      dir_out,
    output logic                      ad_oe,
    output logic [AD_W-1:0]           ad_out,
    input  logic [AD_W-1:0]           ad_in,
    output logic [ADDR_W-18:0]        a_hi,
    output logic [AD_W-1:0]           rd_data,
    output logic                      rd_done
);

    tim_t              tim_sel;
    tim_t              tim_nxt;
    logic              busy_nxt;
    cnt_t              cnt_nxt;
    logic [SEL_W-1:0]  sel_nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_phase;

    mrd_cfg_sel #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cfg (
        .sel       (req_cs),
        .cs_words  (cfg_cs_words),
        .adv_words (cfg_adv_words),
        .oe_words  (cfg_oe_words),
        .tim       (tim_sel)
    );

    mrd_sequencer #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .tim_in    (tim_sel),
        .ad_in     (ad_in),
        .req_ready (req_ready),
        .busy_nxt  (busy_nxt),
        .cnt_nxt   (cnt_nxt),
        .tim_nxt   (tim_nxt),
        .sel_nxt   (sel_nxt),
        .addr_q    (addr_q),
        .rd_data   (rd_data),
        .rd_done   (rd_done)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        mrd_strobe u_cs (
            .clk   (clk),
            .rst   (rst),
            .en    (busy_nxt && (sel_nxt == SEL_W'(i))),
            .cnt   (cnt_nxt),
            .on    (tim_nxt.cs_on),
            .off   (tim_nxt.cs_off),
            .act_n (cs_n[i])
        );
    end

    mrd_strobe u_adv (
        .clk   (clk),
        .rst   (rst),
        .en    (busy_nxt),
        .cnt   (cnt_nxt),
        .on    (tim_nxt.adv_on),
        .off   (tim_nxt.adv_off),
        .act_n (adv_n)
    );

    mrd_strobe u_oe (
        .clk   (clk),
        .rst   (rst),
        .en    (busy_nxt),
        .cnt   (cnt_nxt),
        .on    (tim_nxt.oe_on),
        .off   (tim_nxt.oe_off),
        .act_n (oe_n)
    );

    assign addr_phase = busy_nxt && (cnt_nxt < tim_nxt.oe_on);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_out <= 1'b1;
            ad_oe   <= 1'b0;
            be_n    <= 2'b11;
        end else begin
            dir_out <= !busy_nxt || addr_phase;
            ad_oe   <= addr_phase;
            be_n    <= busy_nxt ? 2'b00 : 2'b11;
        end
    end

    assign ad_out = addr_q[16:1];
    assign a_hi   = addr_q[ADDR_W-1:17];

    // R7: output enable never overlaps an outward bus
    p_oe_dir_in_r7: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!dir_out && !ad_oe));

    // R7: the shared bus is only driven while direction is OUT
    p_drive_out_r7: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> dir_out);

    // R1: idle means every strobe is released
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&cs_n && adv_n && oe_n && dir_out && !ad_oe && be_n == 2'b11 && !rd_done));

    // R10: at most one chip select active
    p_one_cs_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R11: byte enables active for the whole access
    p_be_busy_r11: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (be_n == 2'b00));

endmodule

// File: tb/sim_mux_rd_engine.sv
module sim_mux_rd_engine;
    localparam int NUM_CS = 4;
    localparam int ADDR_W = 28;
    localparam int SEL_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [SEL_W-1:0]        req_cs = '0;
    logic [ADDR_W-1:0]       req_addr = '0;
    logic [NUM_CS*13-1:0]    cfg_cs_words = '0;
    logic [NUM_CS*13-1:0]    cfg_adv_words = '0;
    logic [NUM_CS*29-1:0]    cfg_oe_words = '0;
    logic [NUM_CS-1:0]       cs_n;
    logic                    adv_n, oe_n, dir_out, ad_oe, rd_done;
    logic [1:0]              be_n;
    logic [15:0]             ad_out, rd_data;
    logic [15:0]             ad_in = '0;
    logic [ADDR_W-18:0]      a_hi;

    mux_rd_engine #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cs(req_cs), .req_addr(req_addr), .cfg_cs_words(cfg_cs_words),
        .cfg_adv_words(cfg_adv_words), .cfg_oe_words(cfg_oe_words),
        .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .be_n(be_n), .dir_out(dir_out),
        .ad_oe(ad_oe), .ad_out(ad_out), .ad_in(ad_in), .a_hi(a_hi),
        .rd_data(rd_data), .rd_done(rd_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // per-CS timing held by the bench
    int t_cs_on[NUM_CS], t_cs_off[NUM_CS], t_adv_on[NUM_CS], t_adv_off[NUM_CS];
    int t_oe_on[NUM_CS], t_oe_off[NUM_CS], t_acc[NUM_CS], t_cyc[NUM_CS];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit win(input int k, input int on, input int off);
        return (k >= on) && (k < off);
    endfunction

    task automatic load_words();
        for (int i = 0; i < NUM_CS; i++) begin
            cfg_cs_words[i*13 +: 13]  = {5'(t_cs_off[i]), 4'd0, 4'(t_cs_on[i])};
            cfg_adv_words[i*13 +: 13] = {5'(t_adv_off[i]), 4'd0, 4'(t_adv_on[i])};
            cfg_oe_words[i*29 +: 29]  = {5'(t_cyc[i]), 3'd0, 5'(t_acc[i]), 3'd0,
                                         5'(t_oe_off[i]), 3'd0, 5'(t_oe_on[i])};
        end
    endtask

    task automatic rand_cfg(input int i);
        int c;
        c = 8 + int'($urandom % 24);
        t_cyc[i]     = c;
        t_cs_on[i]   = int'($urandom % 4);
        t_cs_off[i]  = t_cs_on[i] + 1 + int'($urandom % (c - t_cs_on[i]));
        t_adv_on[i]  = int'($urandom % 3);
        t_adv_off[i] = t_adv_on[i] + 1 + int'($urandom % 3);
        t_oe_on[i]   = t_adv_off[i] + int'($urandom % 2);
        t_oe_off[i]  = t_oe_on[i] + 1 + int'($urandom % (c - t_oe_on[i]));
        t_acc[i]     = t_oe_on[i] + int'($urandom % (c - t_oe_on[i]));
    endtask

    task automatic set_cfg(input int i, input int cso, input int csf, input int ao, input int af,
                           input int oo, input int of, input int ac, input int cy);
        t_cs_on[i] = cso; t_cs_off[i] = csf; t_adv_on[i] = ao; t_adv_off[i] = af;
        t_oe_on[i] = oo; t_oe_off[i] = of; t_acc[i] = ac; t_cyc[i] = cy;
    endtask

    task automatic check_idle(input string tag);
        chk(req_ready === 1'b1, {tag, " R1 ready"}, 32'(req_ready), 32'd1);
        chk(cs_n === '1 && adv_n === 1'b1 && oe_n === 1'b1, {tag, " R1 strobes"},
            {26'd0, cs_n, adv_n, oe_n}, {26'd0, 4'hf, 2'b11});
        chk(dir_out === 1'b1 && ad_oe === 1'b0, {tag, " R1 bus"}, {30'd0, dir_out, ad_oe}, 32'd2);
        chk(be_n === 2'b11 && rd_done === 1'b0, {tag, " R1 be/done"}, {29'd0, be_n, rd_done}, 32'd6);
    endtask

    task automatic run_access(input int cs, input logic [ADDR_W-1:0] addr);
        logic [15:0] pat_acc;
        logic [NUM_CS-1:0] exp_cs;
        bit addr_ph;
        pat_acc = '0;
        load_words();
        @(negedge clk);
        check_idle("pre");
        req_valid = 1'b1;
        req_cs    = SEL_W'(cs);
        req_addr  = addr;
        @(posedge clk);
        for (int k = 0; k <= t_cyc[cs]; k++) begin
            @(negedge clk);
            exp_cs = '1;
            if (win(k, t_cs_on[cs], t_cs_off[cs])) exp_cs[cs] = 1'b0;
            chk(cs_n === exp_cs, "R4 R10 cs_n", 32'(cs_n), 32'(exp_cs));
            chk(adv_n === !win(k, t_adv_on[cs], t_adv_off[cs]), "R5 adv_n",
                32'(adv_n), 32'(!win(k, t_adv_on[cs], t_adv_off[cs])));
            chk(oe_n === !win(k, t_oe_on[cs], t_oe_off[cs]), "R6 oe_n",
                32'(oe_n), 32'(!win(k, t_oe_on[cs], t_oe_off[cs])));
            addr_ph = (k < t_oe_on[cs]);
            chk(dir_out === addr_ph && ad_oe === addr_ph, "R7 dir/ad_oe",
                {30'd0, dir_out, ad_oe}, {30'd0, addr_ph, addr_ph});
            if (addr_ph)
                chk(ad_out === addr[16:1] && a_hi === addr[ADDR_W-1:17], "R3 address",
                    {5'd0, a_hi, ad_out}, {5'd0, addr[ADDR_W-1:17], addr[16:1]});
            chk(be_n === 2'b00 && req_ready === 1'b0, "R11 R2 be_n/ready",
                {29'd0, be_n, req_ready}, 32'd0);
            chk(rd_done === (k == t_cyc[cs]), "R9 done", 32'(rd_done), 32'(k == t_cyc[cs]));
            if (k == t_cyc[cs]) begin
                chk(rd_data === pat_acc, "R8 R9 rd_data", 32'(rd_data), 32'(pat_acc));
                req_valid = 1'b0;
            end else begin
                // R2: a competing request while busy must be ignored
                req_cs   = SEL_W'((cs + 1 + k) % NUM_CS);
                req_addr = ADDR_W'($urandom);
            end
            ad_in = 16'($urandom);
            if (k == t_acc[cs]) pat_acc = ad_in;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NUM_CS; i++) rand_cfg(i);
        load_words();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("reset");
        chk(rd_data === 16'd0, "R1 rd_data reset", 32'(rd_data), 32'd0);

        // shortest legal access
        set_cfg(0, 0, 2, 0, 1, 1, 2, 1, 2);
        run_access(0, 28'h00a_5a5a);
        // longest access with late chip select
        set_cfg(3, 15, 31, 15, 20, 20, 31, 30, 31);
        run_access(3, 28'hfff_ffff);
        // capture edge coincides with output-enable release, OE on equals ADV off
        set_cfg(1, 1, 9, 0, 3, 3, 6, 5, 9);
        run_access(1, 28'h5a5_0003);
        // back-to-back on another chip select
        set_cfg(2, 0, 4, 0, 2, 2, 4, 3, 4);
        run_access(2, 28'h123_4567);
        run_access(2, 28'h765_4321);

        for (int n = 0; n < 40; n++) begin
            int cs;
            cs = int'($urandom % NUM_CS);
            rand_cfg(cs);
            run_access(cs, ADDR_W'($urandom));
        end

        @(negedge clk);
        check_idle("end");
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule